// File: doc/BRIEF.md
# Double-Buffered 16-bit Output Compare Channel

This block is one compare channel of a timer. It keeps a 16-bit compare value that a host programs over an 8-bit bus. Each write happens one byte at a time. A write to the high-byte address only fills an internal staging byte. A later write to the low-byte address moves the staged byte and the new low byte into the target register together, in a single clock, so the comparator never sees half of an update.

A 4-bit mode code picks one of two paths:
- In the waveform (PWM) modes, host writes land in a shadow register. The shadow is copied into the live compare register only when the counter reports the update point chosen by the mode (its top or its bottom). This keeps every pulse a whole, symmetric length.
- In the plain counting and clear-on-match modes, host writes go straight into the live register.

The channel compares the live value with the counter input on every clock. When they are equal, it sets a sticky match flag that the host clears by writing a 1 to it. The live value is also driven out so the counter can use it as its wrap limit.

The host reads the two compare bytes directly, without the staging byte. These reads show the shadow when buffering is on and the live register otherwise.

Top module: `ocmp_chan`

## Requirements
- R1: An asynchronous active-low reset clears the staging byte, the shadow, the live compare value and the match flag to zero. Reset is released in step with the clock, two cycles after `rst_n` rises.
- R2: The mode decoder works as follows. Codes 0, 4, 12 and 13 are unbuffered. Codes 8 and 9 are buffered and update at the bottom strobe. Every other code is buffered and updates at the top strobe.
- R3: In a buffered mode, a low-byte write changes only the shadow. The live value changes only on a cycle with the selected strobe. The other strobe has no effect.
- R4: A write to address 1 (high byte) only loads the staging byte, and a write to address 3 does nothing. Neither changes the live value or the readable compare bytes.
- R5: A write to address 0 stores {staging byte, data} as one 16-bit word into the target register. The result is visible after that clock edge.
- R6: In an unbuffered mode, a low-byte write goes directly into the live value. Top and bottom strobes have no effect.
- R7: If the selected strobe and a low-byte write fall in the same buffered cycle, the live value takes the shadow's old contents and the shadow takes the new word.
- R8: The read port is combinational and works as follows:
  - Address 0 returns the low byte and address 1 the high byte of the shadow (buffered) or the live value (unbuffered).
  - Address 2 returns the flag in bit 0.
  - Address 3 returns zero.
- R9: When the counter equals the live value, the match flag is set on the next clock edge. It then stays set after the counter moves on.
- R10: Writing a byte with bit 0 set to address 2 clears the flag on the next edge. A match in that same cycle wins and keeps the flag set. A write with bit 0 clear has no effect.
- R11: The `cmp_top` output always carries the live compare value, for use as the counter's wrap limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 flag, 3 unused |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for `bus_addr` |
| cnt_val | input | 16 | Current counter value |
| mode | input | 4 | Operating mode code |
| at_top | input | 1 | Counter is at its top this cycle |
| at_bottom | input | 1 | Counter is at its bottom this cycle |
| match_flag | output | 1 | Sticky compare-match request |
| cmp_top | output | 16 | Live compare value, usable as counter limit |

## Verification
The hardest case to reach is R7, where a low-byte write and the update strobe land on the same edge while the shadow already holds a value different from the live one. The stimulus first parks a known word in the shadow and transfers it. It then parks a second word and stages a third word's high byte. Finally it raises the low-byte write and the top strobe together on one falling edge. That sequence leaves three distinct words whose final placement can be told apart at the ports. A similar race between a flag clear and a fresh match is set up by holding the counter on the live value while the clear is written.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic [1:0] {
    ADR_LO   = 2'd0,
    ADR_HI   = 2'd1,
    ADR_FLAG = 2'd2,
    ADR_NONE = 2'd3
  } ocmp_adr_e;

  typedef struct packed {
    logic buffered;
    logic upd_bottom;
  } ocmp_cfg_t;

endpackage

// File: rtl/ocmp_mode_dec.sv
module ocmp_mode_dec
  import ocmp_pkg::*;
#(
  parameter int MW = 4
) (
  input  logic [MW-1:0] mode,
  output ocmp_cfg_t     cfg
);

  always_comb begin
    cfg.buffered   = 1'b1;
    cfg.upd_bottom = 1'b0;
    case (mode)
      MW'(0), MW'(4), MW'(12), MW'(13): begin
        cfg.buffered   = 1'b0;
        cfg.upd_bottom = 1'b0;
      end
      MW'(8), MW'(9): begin
        cfg.buffered   = 1'b1;
        cfg.upd_bottom = 1'b1;
      end
      default: begin
        cfg.buffered   = 1'b1;
        cfg.upd_bottom = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ocmp_host_if.sv
module ocmp_host_if
  import ocmp_pkg::*;
#(
  parameter int BW = 8,
  localparam int W = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [BW-1:0] wdata,
  input  logic [W-1:0]  view_word,
  input  logic          flag,
  output logic          lo_wr,
  output logic          flag_clr,
  output logic [W-1:0]  wr_word,
  output logic [BW-1:0] rdata
);

  logic [BW-1:0] temp_q, temp_d;
  logic          temp_en;
  logic          hi_wr;

  always_comb begin
    hi_wr    = wr && (addr == ADR_HI);
    lo_wr    = wr && (addr == ADR_LO);
    flag_clr = wr && (addr == ADR_FLAG) && wdata[0];
    temp_en  = hi_wr;
    temp_d   = wdata;
    wr_word  = {temp_q, wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       temp_q <= '0;
    else if (temp_en) temp_q <= temp_d;
  end

  always_comb begin
    case (addr)
      ADR_LO:   rdata = view_word[BW-1:0];
      ADR_HI:   rdata = view_word[W-1:BW];
      ADR_FLAG: rdata = {{(BW-1){1'b0}}, flag};
      default:  rdata = '0;
    endcase
  end

  AST_TEMP_LOADS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (temp_q == $past(wdata)));  // R4

  AST_TEMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(temp_q));  // R4

endmodule

// File: rtl/ocmp_regs.sv
module ocmp_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lo_wr,
  input  logic [W-1:0] wr_word,
  input  logic         buffered,
  input  logic         xfer,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q
);

  logic [W-1:0] buf_d, act_d;
  logic         buf_en, act_en;

  always_comb begin
    buf_en = lo_wr && buffered;
    buf_d  = wr_word;
    act_en = xfer || (lo_wr && !buffered);
    act_d  = xfer ? buf_q : wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= act_d;
  end

  AST_XFER_TAKES_OLD_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (act_q == $past(buf_q)));  // R7

  AST_LIVE_WAITS_FOR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !xfer) |=> $stable(act_q));  // R3

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !buffered) |=> (act_q == $past(wr_word)));  // R5

  AST_SHADOW_IDLE_UNBUF: assert property (@(posedge clk) disable iff (!rst_n)
    (!buffered) |=> $stable(buf_q));  // R6

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] act_val,
  input  logic         clr,
  output logic         flag_q
);

  logic hit, flag_d;

  always_comb begin
    hit    = (cnt_val == act_val);
    flag_d = hit || (flag_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  AST_FLAG_SETS_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);  // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);  // R9

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr && !hit) |=> !flag_q);  // R10

endmodule

// File: rtl/ocmp_chan.sv
module ocmp_chan
  import ocmp_pkg::*;
#(
  parameter int BW = 8,
  parameter int MW = 4,
  localparam int W = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic [W-1:0]  cnt_val,
  input  logic [MW-1:0] mode,
  input  logic          at_top,
  input  logic          at_bottom,
  output logic          match_flag,
  output logic [W-1:0]  cmp_top
);

  logic [1:0]   rst_sync_q;
  logic         rst_n_int;
  ocmp_cfg_t    cfg;
  logic         lo_wr, flag_clr, xfer;
  logic [W-1:0] wr_word, buf_q, act_q, view_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  ocmp_mode_dec #(.MW(MW)) mode_dec_i (
    .mode (mode),
    .cfg  (cfg)
  );

  always_comb begin
    xfer      = cfg.buffered && (cfg.upd_bottom ? at_bottom : at_top);
    view_word = cfg.buffered ? buf_q : act_q;
  end

  ocmp_host_if #(.BW(BW)) host_if_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .view_word (view_word),
    .flag      (match_flag),
    .lo_wr     (lo_wr),
    .flag_clr  (flag_clr),
    .wr_word   (wr_word),
    .rdata     (bus_rdata)
  );

  ocmp_regs #(.W(W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .lo_wr    (lo_wr),
    .wr_word  (wr_word),
    .buffered (cfg.buffered),
    .xfer     (xfer),
    .buf_q    (buf_q),
    .act_q    (act_q)
  );

  ocmp_match #(.W(W)) match_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cnt_val (cnt_val),
    .act_val (act_q),
    .clr     (flag_clr),
    .flag_q  (match_flag)
  );

  assign cmp_top = act_q;

  AST_UNBUF_IGNORES_STROBES: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!cfg.buffered && !(bus_wr && bus_addr == ADR_LO)) |=> $stable(cmp_top));  // R6

  AST_BOTTOM_ONLY_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n_int)
    cfg.upd_bottom |-> cfg.buffered);  // R2

endmodule

// File: tb/ocmp_chan_tb_top.sv
module ocmp_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt_val;
  logic [3:0]  mode;
  logic        at_top, at_bottom;
  logic        match_flag;
  logic [15:0] cmp_top;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ocmp_chan dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_val),
    .mode(mode), .at_top(at_top), .at_bottom(at_bottom),
    .match_flag(match_flag), .cmp_top(cmp_top)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic write16(logic [15:0] v);
    bus_write(2'd1, v[15:8]);
    bus_write(2'd0, v[7:0]);
  endtask

  task automatic strobe(logic t, logic b);
    @(negedge clk);
    at_top = t; at_bottom = b;
    @(negedge clk);
    at_top = 1'b0; at_bottom = 1'b0;
  endtask

  task automatic read_chk(string req, logic [1:0] a, logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, {8'h00, bus_rdata}, {8'h00, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 live", cmp_top, 16'h0000);
    check("R1 flag", {15'b0, match_flag}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 live after release", cmp_top, 16'h0000);
    read_chk("R1 read low", 2'd0, 8'h00);
    read_chk("R1 read high", 2'd1, 8'h00);
  endtask

  task automatic t_unbuffered();
    mode = 4'd0;
    bus_write(2'd1, 8'h12);
    check("R4 high write only stages", cmp_top, 16'h0000);
    read_chk("R4 high write not readable", 2'd1, 8'h00);
    bus_write(2'd0, 8'h34);
    check("R5 R6 direct write", cmp_top, 16'h1234);
    check("R11 limit output", cmp_top, 16'h1234);
    strobe(1'b1, 1'b1);
    check("R6 strobes ignored", cmp_top, 16'h1234);
    read_chk("R8 read high", 2'd1, 8'h12);
    read_chk("R8 read low", 2'd0, 8'h34);
    bus_write(2'd3, 8'hEE);
    check("R4 addr3 write ignored", cmp_top, 16'h1234);
    read_chk("R8 addr3 reads zero", 2'd3, 8'h00);
  endtask

  task automatic t_buffered_top();
    mode = 4'd1;
    write16(16'hABCD);
    check("R3 live unchanged by write", cmp_top, 16'h1234);
    read_chk("R8 shadow low", 2'd0, 8'hCD);
    read_chk("R8 shadow high", 2'd1, 8'hAB);
    strobe(1'b0, 1'b1);
    check("R3 wrong strobe ignored", cmp_top, 16'h1234);
    strobe(1'b1, 1'b0);
    check("R3 top transfer", cmp_top, 16'hABCD);
  endtask

  task automatic t_bottom_mode();
    mode = 4'd8;
    write16(16'h5555);
    strobe(1'b1, 1'b0);
    check("R2 mode8 ignores top", cmp_top, 16'hABCD);
    strobe(1'b0, 1'b1);
    check("R2 mode8 bottom transfer", cmp_top, 16'h5555);
    mode = 4'd12;
    write16(16'h0102);
    check("R2 mode12 unbuffered", cmp_top, 16'h0102);
    mode = 4'd13;
    write16(16'h0203);
    check("R2 mode13 unbuffered", cmp_top, 16'h0203);
  endtask

  task automatic t_collision();
    mode = 4'd3;
    write16(16'h4444);
    strobe(1'b1, 1'b0);
    check("R3 mode3 top transfer", cmp_top, 16'h4444);
    write16(16'h6666);
    bus_write(2'd1, 8'h77);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h88; at_top = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; at_top = 1'b0;
    check("R7 live takes old shadow", cmp_top, 16'h6666);
    read_chk("R7 shadow low new", 2'd0, 8'h88);
    read_chk("R7 shadow high new", 2'd1, 8'h77);
    strobe(1'b1, 1'b0);
    check("R7 next transfer", cmp_top, 16'h7788);
  endtask

  task automatic t_match();
    bus_write(2'd2, 8'h01);
    check("R10 flag cleared", {15'b0, match_flag}, 16'h0000);
    @(negedge clk);
    cnt_val = 16'h7788;
    #1;
    check("R9 flag registered", {15'b0, match_flag}, 16'h0000);
    @(negedge clk);
    check("R9 flag set", {15'b0, match_flag}, 16'h0001);
    cnt_val = 16'hFFFF;
    @(negedge clk);
    check("R9 flag sticky", {15'b0, match_flag}, 16'h0001);
    read_chk("R8 flag read", 2'd2, 8'h01);
    bus_write(2'd2, 8'hFE);
    check("R10 bit0 clear no effect", {15'b0, match_flag}, 16'h0001);
    bus_write(2'd2, 8'h01);
    check("R10 clear", {15'b0, match_flag}, 16'h0000);
    read_chk("R8 flag read zero", 2'd2, 8'h00);
    cnt_val = 16'h7788;
    bus_write(2'd2, 8'h01);
    cnt_val = 16'hFFFF;
    check("R10 match wins over clear", {15'b0, match_flag}, 16'h0001);
    bus_write(2'd2, 8'h01);
    check("R10 clear after race", {15'b0, match_flag}, 16'h0000);
  endtask

  task automatic t_reset_midrun();
    do_reset();
    check("R1 flag after reset", {15'b0, match_flag}, 16'h0000);
    mode = 4'd0;
    bus_write(2'd0, 8'h99);
    check("R1 staging byte cleared", cmp_top, 16'h0099);
  endtask

  initial begin
    rst_n = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    cnt_val = 16'hFFFF; mode = 4'd0; at_top = 1'b0; at_bottom = 1'b0;
    t_reset_state();
    t_unbuffered();
    t_buffered_top();
    t_bottom_mode();
    t_collision();
    t_match();
    t_reset_midrun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule